// File: doc/BRIEF.md
# Three-Phase Inverter Switching-Function Voltage Model

This block is the per-step inverter stage of a real-time converter emulator. Once per simulation step it reads the six gate levels from an external controller, the DC-link voltage and the three load currents. From these it produces the three pole voltages, the three line-to-line voltages, the three phase voltages, the six per-device currents and the current the bridge draws from the DC link. All values are signed fixed-point integers that share one LSB scale. The block is meant to be stepped every 100 ns, which is a 10 MHz step rate, from a faster fabric clock.

Each leg has a two-valued switching function. It is +1 when the upper device is gated and −1 otherwise, and it sets the pole voltage to plus or minus half the link voltage. Each device also has a conduction function. It is 1 when that device is gated and 0 when it is not, and it steers the leg's load current into that device. A mode input selects ideal devices or lossy devices. A lossy device adds three terms to its drop: a resistive term, a fixed forward drop and an inductive term. The resistive term and the forward drop follow the sign of the current. The inductive term is a forward-Euler step: the change in current since the previous step, times a coefficient that stands for L/Ts. A sudden change of current therefore shows up as a voltage spike at commutation.

The datapath has two register stages. A one-cycle valid pulse marks each new result, and the outputs hold their values between steps.

Top module: `vsi_swfn_model`

## Requirements
- R1: In ideal mode (`nonideal_i`=0), the pole voltage of a leg is `vdc_i>>>1` when that leg's upper gate is 1, and `-(vdc_i>>>1)` when it is 0. The lower gate does not affect the pole voltage. Leg a is bit 0 of the gate buses, b is bit 1 and c is bit 2.
- R2: The upper device current of a leg equals the leg's load current when its upper gate is 1 and 0 otherwise. The lower device current follows the lower gate in the same way.
- R3: `i_dc_o` is the sum of the three upper device currents, saturated to the DW-bit signed range.
- R4: The line outputs are ab = a−b, bc = b−c and ca = c−a, taken from the pole outputs of the same step. Each is DW+1 bits wide and exact, so the three always sum to zero.
- R5: The phase voltage of leg k is (2·pole_k − pole_(k+1) − pole_(k+2))/3, with the leg index taken modulo 3. The division truncates toward zero and the result is saturated to DW bits.
- R6: In lossy mode, the resistive and forward term of a leg is s·(((|i|·RON_MUL)>>>RON_SH) + VF_DROP), where s is the sign of the load current (+1, −1, or 0 for zero current). This term is subtracted from the ideal pole voltage.
- R7: In lossy mode, the inductive term ((i − i_prev)·LDI_MUL)>>>LDI_SH is also subtracted from the pole voltage. Here i_prev is the leg's load current sampled at the previous step, and it is 0 after reset. The shift is arithmetic, so it rounds toward minus infinity.
- R8: Inputs are sampled on the clock edge where `step_i` is 1. `out_valid_o` is a single-cycle pulse two clock edges after that edge. When `out_valid_o` is 0, every output keeps its previous value.
- R9: A pole voltage beyond the DW-bit signed range saturates to the nearest limit.
- R10: During synchronous active-low reset, all outputs and the previous-current memory clear to 0 and `out_valid_o` is 0.
- R11: Changing the mode, the gates, the link voltage or the currents while `step_i` is 0 changes no output, and the stored previous current stays as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Synchronous reset, active low |
| step_i | input | 1 | Simulation-step strobe |
| nonideal_i | input | 1 | 1 selects lossy devices, 0 ideal |
| gate_hi_i | input | 3 | Upper gate per leg (bit0=a) |
| gate_lo_i | input | 3 | Lower gate per leg (bit0=a) |
| vdc_i | input | DW | DC-link voltage, signed |
| i_load_i | input | 3*DW | Load currents, leg k at [k*DW +: DW] |
| v_pole_o | output | 3*DW | Pole voltages per leg |
| v_line_o | output | 3*(DW+1) | Line voltages ab, bc, ca |
| v_phase_o | output | 3*DW | Phase voltages per leg |
| i_hi_o | output | 3*DW | Upper device currents |
| i_lo_o | output | 3*DW | Lower device currents |
| i_dc_o | output | DW | DC input current |
| out_valid_o | output | 1 | One-cycle result strobe |

## Verification
Several properties are checked on every cycle:
- the line voltages sum to zero;
- the valid pulse arrives exactly two edges after a step;
- outputs hold still whenever valid is low;
- in ideal mode each pole voltage equals plus or minus half of the link voltage sampled at the step;
- with no upper gate on, the link current is zero.

Other behaviour needs the bench's directed scenarios. These cover the signed resistive and forward drop, the Euler current difference carried across consecutive steps, saturation of the pole, phase and link current, and the phase division's rounding.

// File: rtl/vsi_pkg.sv
// Package: shared constants and types for the inverter switching-function model.
// Assumes three legs ordered a, b, c at indices 0, 1, 2.
package vsi_pkg;
    localparam int NLEG = 3;

    // Device model selected at each step.
    typedef enum logic {
        SW_IDEAL = 1'b0,
        SW_LOSSY = 1'b1
    } sw_mode_e;
endpackage

// File: rtl/vsi_leg.sv
// One inverter leg: switching function, conduction function, lossy drop and
// pole voltage. Registers its results on a step strobe and keeps the load
// current of the previous step for the forward-Euler derivative.
// Assumes all quantities share one LSB scale; LDI_MUL stands for L/Ts.
module vsi_leg
    import vsi_pkg::*;
#(
    parameter int DW      = 16,
    parameter int RON_MUL = 3,
    parameter int RON_SH  = 4,
    parameter int VF_DROP = 20,
    parameter int LDI_MUL = 5,
    parameter int LDI_SH  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 step_i,
    input  sw_mode_e             mode_i,
    input  logic                 gate_hi_i,
    input  logic                 gate_lo_i,
    input  logic signed [DW-1:0] vdc_i,
    input  logic signed [DW-1:0] i_load_i,
    output logic signed [DW-1:0] pole_o,
    output logic signed [DW-1:0] i_hi_o,
    output logic signed [DW-1:0] i_lo_o
);
    localparam int WW = DW + 16;
    localparam logic signed [WW-1:0] MAXV  = (WW'(1) <<< (DW - 1)) - WW'(1);
    localparam logic signed [WW-1:0] MINV  = -MAXV - WW'(1);
    localparam logic signed [WW-1:0] K_RON = WW'(RON_MUL);
    localparam logic signed [WW-1:0] K_VF  = WW'(VF_DROP);
    localparam logic signed [WW-1:0] K_LDI = WW'(LDI_MUL);

    logic signed [DW-1:0] i_prev;
    logic signed [WW-1:0] vdc_w, i_w, ip_w, half, ideal, mag;
    logic signed [WW-1:0] rterm, rf, di, lterm, pole_raw;

    // Clamp a wide value into the DW-bit signed range.
    function automatic logic signed [DW-1:0] sat_dw(input logic signed [WW-1:0] x);
        if (x > MAXV)      return MAXV[DW-1:0];
        else if (x < MINV) return MINV[DW-1:0];
        else               return x[DW-1:0];
    endfunction

    // Pole voltage from the switching function plus the optional device drop.
    always_comb begin
        vdc_w = WW'(vdc_i);
        i_w   = WW'(i_load_i);
        ip_w  = WW'(i_prev);
        half  = vdc_w >>> 1;
        ideal = gate_hi_i ? half : -half;
        mag   = i_w[WW-1] ? -i_w : i_w;
        rterm = (mag * K_RON) >>> RON_SH;
        if (i_w[WW-1])         rf = -(rterm + K_VF);
        else if (i_w != '0)    rf = rterm + K_VF;
        else                   rf = '0;
        di    = i_w - ip_w;
        lterm = (di * K_LDI) >>> LDI_SH;
        pole_raw = (mode_i == SW_LOSSY) ? (ideal - rf - lterm) : ideal;
    end

    // Stage A: register the leg results and the current sample at each step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pole_o <= '0;
            i_hi_o <= '0;
            i_lo_o <= '0;
            i_prev <= '0;
        end else if (step_i) begin
            pole_o <= sat_dw(pole_raw);
            i_hi_o <= gate_hi_i ? i_load_i : '0;
            i_lo_o <= gate_lo_i ? i_load_i : '0;
            i_prev <= i_load_i;
        end
    end
endmodule

// File: rtl/vsi_dc_sum.sv
// DC input current: the sum of the upper device currents, saturated.
// Purely combinational; assumes NLEG small (three legs).
module vsi_dc_sum
    import vsi_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic signed [DW-1:0] i_hi_i [NLEG],
    output logic signed [DW-1:0] i_dc_o
);
    localparam int WW = DW + 4;
    localparam logic signed [WW-1:0] MAXV = (WW'(1) <<< (DW - 1)) - WW'(1);
    localparam logic signed [WW-1:0] MINV = -MAXV - WW'(1);

    logic signed [WW-1:0] acc;

    // Accumulate the legs, then clamp to the output range.
    always_comb begin
        acc = '0;
        for (int k = 0; k < NLEG; k++) acc = acc + WW'(i_hi_i[k]);
        if (acc > MAXV)      i_dc_o = MAXV[DW-1:0];
        else if (acc < MINV) i_dc_o = MINV[DW-1:0];
        else                 i_dc_o = acc[DW-1:0];
    end
endmodule

// File: rtl/vsi_out_stage.sv
// Stage B: line and phase voltages from the stage-A pole voltages, and the
// output registers for every result. Loads only when stage A has new data.
// Assumes pole inputs are stable for the cycle in which ld_i is high.
module vsi_out_stage
    import vsi_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ld_i,
    input  logic signed [DW-1:0] pole_i  [NLEG],
    input  logic signed [DW-1:0] ihi_i   [NLEG],
    input  logic signed [DW-1:0] ilo_i   [NLEG],
    input  logic signed [DW-1:0] idc_i,
    output logic signed [DW-1:0] pole_o  [NLEG],
    output logic signed [DW:0]   line_o  [NLEG],
    output logic signed [DW-1:0] phase_o [NLEG],
    output logic signed [DW-1:0] ihi_o   [NLEG],
    output logic signed [DW-1:0] ilo_o   [NLEG],
    output logic signed [DW-1:0] idc_o
);
    localparam int PW = DW + 3;
    localparam logic signed [PW-1:0] THREE = PW'(3);
    localparam logic signed [PW-1:0] MAXV  = (PW'(1) <<< (DW - 1)) - PW'(1);
    localparam logic signed [PW-1:0] MINV  = -MAXV - PW'(1);

    logic signed [DW:0]   line_c  [NLEG];
    logic signed [DW-1:0] phase_c [NLEG];

    // Line differences (exact) and saturated one-third phase voltages.
    always_comb begin
        for (int k = 0; k < NLEG; k++) begin
            logic signed [PW-1:0] num, q;
            line_c[k] = (DW+1)'(pole_i[k]) - (DW+1)'(pole_i[(k + 1) % NLEG]);
            num = (PW'(pole_i[k]) <<< 1) - PW'(pole_i[(k + 1) % NLEG])
                  - PW'(pole_i[(k + 2) % NLEG]);
            q = num / THREE;
            if (q > MAXV)      phase_c[k] = MAXV[DW-1:0];
            else if (q < MINV) phase_c[k] = MINV[DW-1:0];
            else               phase_c[k] = q[DW-1:0];
        end
    end

    // Output registers, updated once per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NLEG; k++) begin
                pole_o[k]  <= '0;
                line_o[k]  <= '0;
                phase_o[k] <= '0;
                ihi_o[k]   <= '0;
                ilo_o[k]   <= '0;
            end
            idc_o <= '0;
        end else if (ld_i) begin
            for (int k = 0; k < NLEG; k++) begin
                pole_o[k]  <= pole_i[k];
                line_o[k]  <= line_c[k];
                phase_o[k] <= phase_c[k];
                ihi_o[k]   <= ihi_i[k];
                ilo_o[k]   <= ilo_i[k];
            end
            idc_o <= idc_i;
        end
    end
endmodule

// File: rtl/vsi_swfn_model.sv
// Top: three-phase two-level inverter modelled by switching functions.
// Three leg slices (stage A) feed a DC-current adder and the output stage
// (stage B); results appear two edges after a step with a valid pulse.
// Assumes the step strobe is a single-cycle pulse at most every two cycles.
module vsi_swfn_model
    import vsi_pkg::*;
#(
    parameter int DW      = 16,
    parameter int RON_MUL = 3,
    parameter int RON_SH  = 4,
    parameter int VF_DROP = 20,
    parameter int LDI_MUL = 5,
    parameter int LDI_SH  = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  step_i,
    input  logic                  nonideal_i,
    input  logic [2:0]            gate_hi_i,
    input  logic [2:0]            gate_lo_i,
    input  logic signed [DW-1:0]  vdc_i,
    input  logic [3*DW-1:0]       i_load_i,
    output logic [3*DW-1:0]       v_pole_o,
    output logic [3*(DW+1)-1:0]   v_line_o,
    output logic [3*DW-1:0]       v_phase_o,
    output logic [3*DW-1:0]       i_hi_o,
    output logic [3*DW-1:0]       i_lo_o,
    output logic signed [DW-1:0]  i_dc_o,
    output logic                  out_valid_o
);
    sw_mode_e             mode;
    logic                 stage_a_vld;
    logic signed [DW-1:0] pole_a [NLEG];
    logic signed [DW-1:0] ihi_a  [NLEG];
    logic signed [DW-1:0] ilo_a  [NLEG];
    logic signed [DW-1:0] idc_a;
    logic signed [DW-1:0] pole_q [NLEG];
    logic signed [DW:0]   line_q [NLEG];
    logic signed [DW-1:0] phase_q[NLEG];
    logic signed [DW-1:0] ihi_q  [NLEG];
    logic signed [DW-1:0] ilo_q  [NLEG];

    // Decode the mode pin into the device-model type.
    assign mode = nonideal_i ? SW_LOSSY : SW_IDEAL;

    // Leg slices and output packing.
    for (genvar g = 0; g < NLEG; g++) begin : g_leg
        vsi_leg #(
            .DW(DW), .RON_MUL(RON_MUL), .RON_SH(RON_SH), .VF_DROP(VF_DROP),
            .LDI_MUL(LDI_MUL), .LDI_SH(LDI_SH)
        ) leg_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .step_i   (step_i),
            .mode_i   (mode),
            .gate_hi_i(gate_hi_i[g]),
            .gate_lo_i(gate_lo_i[g]),
            .vdc_i    (vdc_i),
            .i_load_i (i_load_i[g*DW +: DW]),
            .pole_o   (pole_a[g]),
            .i_hi_o   (ihi_a[g]),
            .i_lo_o   (ilo_a[g])
        );
        assign v_pole_o [g*DW +: DW]         = pole_q[g];
        assign v_line_o [g*(DW+1) +: (DW+1)] = line_q[g];
        assign v_phase_o[g*DW +: DW]         = phase_q[g];
        assign i_hi_o   [g*DW +: DW]         = ihi_q[g];
        assign i_lo_o   [g*DW +: DW]         = ilo_q[g];
    end

    vsi_dc_sum #(.DW(DW)) dc_i (
        .i_hi_i(ihi_a),
        .i_dc_o(idc_a)
    );

    vsi_out_stage #(.DW(DW)) out_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld_i   (stage_a_vld),
        .pole_i (pole_a),
        .ihi_i  (ihi_a),
        .ilo_i  (ilo_a),
        .idc_i  (idc_a),
        .pole_o (pole_q),
        .line_o (line_q),
        .phase_o(phase_q),
        .ihi_o  (ihi_q),
        .ilo_o  (ilo_q),
        .idc_o  (i_dc_o)
    );

    // Valid pipeline that tracks the two register stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_a_vld <= 1'b0;
            out_valid_o <= 1'b0;
        end else begin
            stage_a_vld <= step_i;
            out_valid_o <= stage_a_vld;
        end
    end

    // Wide sum of the line outputs, used by the zero-sum property.
    logic signed [DW+2:0] line_sum;
    always_comb line_sum = (DW+3)'(line_q[0]) + (DW+3)'(line_q[1]) + (DW+3)'(line_q[2]);

    p_valid_timing_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> $past(step_i, 2));

    p_hold_between_steps_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid_o |-> ($stable(v_pole_o) && $stable(v_line_o) && $stable(v_phase_o)
                          && $stable(i_dc_o)));

    p_line_sum_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        line_sum == '0);

    p_dc_zero_when_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && ($past(gate_hi_i, 2) == 3'b000)) |-> (i_dc_o == '0));

    for (genvar g = 0; g < NLEG; g++) begin : g_chk
        p_ideal_pole_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid_o && !$past(nonideal_i, 2)) |->
            ((pole_q[g] == ($past(vdc_i, 2) >>> 1)) ||
             (pole_q[g] == -($past(vdc_i, 2) >>> 1))));
    end
endmodule

// File: tb/vsi_swfn_model_tb_top.sv
// Directed bench for the switching-function inverter model.
module vsi_swfn_model_tb_top;
    localparam int DW = 16, RON_MUL = 3, RON_SH = 4, VF_DROP = 20, LDI_MUL = 5, LDI_SH = 2;

    logic clk = 1'b0, rst_n = 1'b0, step = 1'b0, nonideal = 1'b0;
    logic [2:0] ghi = '0, glo = '0;
    logic signed [DW-1:0] vdc = '0;
    logic [3*DW-1:0] iload = '0;
    logic [3*DW-1:0] vpole, vphase, ihi, ilo;
    logic [3*(DW+1)-1:0] vline;
    logic signed [DW-1:0] idc;
    logic valid;

    int errors = 0, checks = 0;
    longint ip [3];
    bit done = 0;

    always #2ns clk = ~clk;

    vsi_swfn_model #(.DW(DW), .RON_MUL(RON_MUL), .RON_SH(RON_SH), .VF_DROP(VF_DROP),
                     .LDI_MUL(LDI_MUL), .LDI_SH(LDI_SH)) dut_i (
        .clk(clk), .rst_n(rst_n), .step_i(step), .nonideal_i(nonideal),
        .gate_hi_i(ghi), .gate_lo_i(glo), .vdc_i(vdc), .i_load_i(iload),
        .v_pole_o(vpole), .v_line_o(vline), .v_phase_o(vphase),
        .i_hi_o(ihi), .i_lo_o(ilo), .i_dc_o(idc), .out_valid_o(valid));

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic longint sat(input longint x);
        if (x > 32767) return 32767;
        if (x < -32768) return -32768;
        return x;
    endfunction

    function automatic longint pole_s(int k);  return longint'($signed(vpole[k*DW +: DW]));     endfunction
    function automatic longint phase_s(int k); return longint'($signed(vphase[k*DW +: DW]));    endfunction
    function automatic longint line_s(int k);  return longint'($signed(vline[k*(DW+1) +: DW+1])); endfunction
    function automatic longint ihi_s(int k);   return longint'($signed(ihi[k*DW +: DW]));       endfunction
    function automatic longint ilo_s(int k);   return longint'($signed(ilo[k*DW +: DW]));       endfunction

    // Expected pole voltage from R1, R6, R7 and R9.
    function automatic longint exp_pole(bit hi, bit ni, longint v, longint i, longint iprev);
        longint half, ideal, mag, r, rf, l;
        half  = v >>> 1;
        ideal = hi ? half : -half;
        if (!ni) return sat(ideal);
        mag = (i < 0) ? -i : i;
        r   = (mag * RON_MUL) >>> RON_SH;
        rf  = (i > 0) ? r + VF_DROP : ((i < 0) ? -(r + VF_DROP) : 0);
        l   = ((i - iprev) * LDI_MUL) >>> LDI_SH;
        return sat(ideal - rf - l);
    endfunction

    // Apply one step, check the valid timing, then every output.
    task automatic do_step(input string ptag, input bit [2:0] hi, input bit [2:0] lo, input bit ni,
                           input longint v, input longint ia, input longint ib, input longint ic);
        longint cur [3];
        longint ep [3];
        longint sum;
        cur[0] = ia; cur[1] = ib; cur[2] = ic;
        @(negedge clk);
        ghi = hi; glo = lo; nonideal = ni; vdc = DW'(v);
        iload = {DW'(ic), DW'(ib), DW'(ia)};
        step = 1'b1;
        @(negedge clk);
        step = 1'b0;
        chk("R8", "valid one cycle after step", longint'(valid), 0);
        @(negedge clk);
        chk("R8", "valid two cycles after step", longint'(valid), 1);
        for (int k = 0; k < 3; k++) ep[k] = exp_pole(hi[k], ni, v, cur[k], ip[k]);
        sum = 0;
        for (int k = 0; k < 3; k++) begin
            chk(ptag, $sformatf("pole %0d", k), pole_s(k), ep[k]);
            chk("R4", $sformatf("line %0d", k), line_s(k), ep[k] - ep[(k+1)%3]);
            chk("R5", $sformatf("phase %0d", k), phase_s(k),
                sat((2*ep[k] - ep[(k+1)%3] - ep[(k+2)%3]) / 3));
            chk("R2", $sformatf("upper current %0d", k), ihi_s(k), hi[k] ? cur[k] : 0);
            chk("R2", $sformatf("lower current %0d", k), ilo_s(k), lo[k] ? cur[k] : 0);
            if (hi[k]) sum += cur[k];
            ip[k] = cur[k];
        end
        chk("R3", "dc current", longint'(idc), sat(sum));
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            chk("R10", "pole in reset", pole_s(k), 0);
            chk("R10", "phase in reset", phase_s(k), 0);
            ip[k] = 0;
        end
        chk("R10", "dc current in reset", longint'(idc), 0);
        chk("R10", "valid in reset", longint'(valid), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_ideal();
        do_step("R1", 3'b101, 3'b010, 1'b0, 1000, 100, -50, -50);
        do_step("R1", 3'b000, 3'b111, 1'b0, 1000, 100, -50, -50);
        do_step("R1", 3'b111, 3'b000, 1'b0, 801, -300, 120, 180);
        do_step("R1", 3'b010, 3'b101, 1'b0, 600, 7, -9, 2);
    endtask

    task automatic t_lossy();
        do_step("R6", 3'b100, 3'b011, 1'b1, 1000, 200, -200, 0);
        do_step("R6", 3'b100, 3'b011, 1'b1, 1000, 200, -200, 0);
        do_step("R7", 3'b001, 3'b110, 1'b1, 1000, -150, 90, 37);
        do_step("R7", 3'b011, 3'b100, 1'b1, 1200, 33, 90, -401);
    endtask

    task automatic t_saturation();
        do_step("R9", 3'b001, 3'b110, 1'b1, 32767, 32767, -32768, -32768);
        do_step("R9", 3'b001, 3'b110, 1'b1, 32767, -32768, 32767, 32767);
        do_step("R3", 3'b111, 3'b000, 1'b0, 500, 30000, 30000, 30000);
    endtask

    // R11: input changes without a step leave outputs and history untouched.
    task automatic t_no_step();
        longint p0, l0;
        do_step("R1", 3'b110, 3'b001, 1'b0, 900, 10, 20, 30);
        p0 = pole_s(0); l0 = line_s(1);
        @(negedge clk);
        nonideal = 1'b1; ghi = 3'b001; vdc = 16'sd5000; iload = '1;
        repeat (4) begin
            @(negedge clk);
            chk("R11", "valid without step", longint'(valid), 0);
        end
        chk("R11", "pole held", pole_s(0), p0);
        chk("R11", "line held", line_s(1), l0);
        // The Euler term must still see the current of the last real step.
        do_step("R11", 3'b000, 3'b111, 1'b1, 900, 50, 20, -30);
    endtask

    initial begin
        #(4ns * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_ideal();
        t_lossy();
        t_saturation();
        t_no_step();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule